// File: doc/BRIEF.md
# Priority Interrupt Acknowledge Handler

This block is the bus-side half of an interrupt handler on a backplane with seven wired, active-low priority request lines. A seven-bit ownership mask tells it which levels it services, so one instance can own every level or several instances can split the levels between them. When an owned line is low, the block picks the most urgent one, runs an acknowledge cycle for it and waits for the interrupter's data strobe. It then latches the status/ID word from the data bus and hands it, with the level number, to local software.

The result leaves through a one-entry valid/ready port, and `res_valid` doubles as the local interrupt request. Back-pressure rules: while `res_valid` is high and `res_ready` is low, the payload holds still and no new acknowledge cycle is started. The entry drains on any clock edge where both are high. A shared line that is still low after its result has drained gets a fresh acknowledge cycle, so several interrupters on one level are served one after another. If no strobe arrives within `tmo_limit` cycles, the block gives up on that cycle and posts a result flagged as a timeout.

All inputs are taken to be synchronous to `clk`.

Top module: `irq_ack_handler`

## Requirements
- R1: While reset is applied and right after it, `ack_n` is high, `lvl_addr` is 0 and `res_valid` is low.
- R2: Bit i of `req_n` and `own_mask` stands for level i+1. Among the levels that are both low on `req_n` and set in `own_mask`, the highest number is acknowledged, and `lvl_addr` carries that number in binary (1 to 7).
- R3: A level whose `own_mask` bit is 0 is ignored: if no owned line is low, `ack_n` stays high.
- R4: With the result port empty and `dtack_n` high, `ack_n` goes low on the first clock edge that sees an owned request. `lvl_addr` does not change while `ack_n` stays low.
- R5: When `dtack_n` is low during an acknowledge, the next edge raises `ack_n`, sets `res_valid`, and stores `bus_data` in `res_id` and the level in `res_level`, with `res_timeout` = 0.
- R6: After a completed cycle, `ack_n` is not driven low again until `dtack_n` has returned high.
- R7: If `dtack_n` stays high, `ack_n` stays low for exactly `tmo_limit` cycles (a value of 0 acts as 1). It is then released and a result is posted with `res_timeout` = 1, `res_id` = 0 and the level.
- R8: While `res_valid` is high and `res_ready` is low, the payload is stable and `ack_n` stays high. The entry clears on an edge where `res_ready` is high.
- R9: If the same owned line is still low once the result has drained and `dtack_n` is high, a new acknowledge cycle is started on that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| own_mask | input | 7 | Levels owned by this handler, bit i = level i+1 |
| tmo_limit | input | 16 | Cycles to wait for the data strobe |
| req_n | input | 7 | Active-low request lines, bit i = level i+1 |
| ack_n | output | 1 | Active-low acknowledge, start of the daisy chain |
| lvl_addr | output | 3 | Level being acknowledged (address lines 1 to 3) |
| dtack_n | input | 1 | Active-low data strobe from the interrupter |
| bus_data | input | 32 | Status/ID on the data lines |
| res_valid | output | 1 | Result held, also the local interrupt |
| res_ready | input | 1 | Software takes the result |
| res_id | output | 32 | Captured status/ID, 0 on timeout |
| res_level | output | 3 | Level of the result |
| res_timeout | output | 1 | Result is from an abandoned cycle |

## Verification
The bench sweeps every request pattern against a range of ownership masks. Any error in the priority scan or the masking therefore shows up as a wrong `lvl_addr`, or as an acknowledge on a level the handler does not own. A shared line that stays low is served twice while the strobe is held past the result drain. A design without the strobe hold-off would acknowledge again at once, and one without the re-run would stall with the line still low. Timeout lengths of 0, 1 and 6 catch off-by-one errors in the counter and a zero limit that never expires. The result port is held stalled so that a payload overwritten, or a cycle started under back-pressure, would be caught.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACK   = 2'd1,
    ST_DRAIN = 2'd2
  } ack_state_e;
endpackage

// File: rtl/irq_level_picker.sv
// Scans the owned, asserted levels and returns the highest level number.
module irq_level_picker #(
  parameter int LEVELS = 7,
  localparam int LVL_W = $clog2(LEVELS + 1)
) (
  input  logic [LEVELS-1:0] pend,
  output logic              any,
  output logic [LVL_W-1:0]  lvl
);
  always_comb begin
    lvl = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (pend[i]) lvl = LVL_W'(i + 1);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/irq_ack_timer.sv
// Counts cycles in the acknowledge phase; expire flags the final allowed cycle.
module irq_ack_timer #(
  parameter int TMO_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [TMO_W-1:0] limit,
  output logic             expire
);
  logic [TMO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || !run) cnt <= '0;
    else                cnt <= cnt + 1'b1;
  end

  assign expire = ({1'b0, cnt} + (TMO_W+1)'(1)) >= {1'b0, limit};
endmodule

// File: rtl/irq_result_reg.sv
// One-entry result holder with a valid/ready output.
module irq_result_reg #(
  parameter int DATA_W = 32,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              load_tmo,
  input  logic [DATA_W-1:0] load_id,
  input  logic [LVL_W-1:0]  load_lvl,
  output logic              valid,
  input  logic              ready,
  output logic [DATA_W-1:0] id,
  output logic [LVL_W-1:0]  lvl,
  output logic              tmo
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      id    <= '0;
      lvl   <= '0;
      tmo   <= 1'b0;
    end else if (load) begin
      valid <= 1'b1;
      id    <= load_tmo ? '0 : load_id;
      lvl   <= load_lvl;
      tmo   <= load_tmo;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_ack_handler.sv
module irq_ack_handler
  import irq_ack_pkg::*;
#(
  parameter int LEVELS = 7,
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16,
  localparam int LVL_W = $clog2(LEVELS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LEVELS-1:0] own_mask,
  input  logic [TMO_W-1:0]  tmo_limit,
  input  logic [LEVELS-1:0] req_n,
  output logic              ack_n,
  output logic [LVL_W-1:0]  lvl_addr,
  input  logic              dtack_n,
  input  logic [DATA_W-1:0] bus_data,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_id,
  output logic [LVL_W-1:0]  res_level,
  output logic              res_timeout
);
  ack_state_e       state;
  logic             ack_n_q;
  logic [LVL_W-1:0] lvl_q;
  logic             pick_any;
  logic [LVL_W-1:0] pick_lvl;
  logic             tmo_hit;
  logic             done_ok;
  logic             done_tmo;

  irq_level_picker #(.LEVELS(LEVELS)) u_pick (
    .pend (~req_n & own_mask),
    .any  (pick_any),
    .lvl  (pick_lvl)
  );

  irq_ack_timer #(.TMO_W(TMO_W)) u_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (state == ST_ACK),
    .limit  (tmo_limit),
    .expire (tmo_hit)
  );

  assign done_ok  = (state == ST_ACK) && !dtack_n;
  assign done_tmo = (state == ST_ACK) && dtack_n && tmo_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ack_n_q <= 1'b1;
      lvl_q   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (pick_any && !res_valid && dtack_n) begin
            state   <= ST_ACK;
            ack_n_q <= 1'b0;
            lvl_q   <= pick_lvl;
          end
        end
        ST_ACK: begin
          if (done_ok) begin
            state   <= ST_DRAIN;
            ack_n_q <= 1'b1;
          end else if (done_tmo) begin
            state   <= ST_IDLE;
            ack_n_q <= 1'b1;
          end
        end
        ST_DRAIN: begin
          if (dtack_n) state <= ST_IDLE;
        end
        default: begin
          state   <= ST_IDLE;
          ack_n_q <= 1'b1;
        end
      endcase
    end
  end

  irq_result_reg #(.DATA_W(DATA_W), .LVL_W(LVL_W)) u_res (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (done_ok || done_tmo),
    .load_tmo (done_tmo),
    .load_id  (bus_data),
    .load_lvl (lvl_q),
    .valid    (res_valid),
    .ready    (res_ready),
    .id       (res_id),
    .lvl      (res_level),
    .tmo      (res_timeout)
  );

  assign ack_n    = ack_n_q;
  assign lvl_addr = lvl_q;
endmodule

// File: rtl/irq_ack_checker.sv
module irq_ack_checker #(
  parameter int LEVELS = 7,
  parameter int DATA_W = 32,
  parameter int TMO_W  = 16,
  localparam int LVL_W = $clog2(LEVELS + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [LEVELS-1:0] own_mask,
  input logic [TMO_W-1:0]  tmo_limit,
  input logic              ack_n,
  input logic [LVL_W-1:0]  lvl_addr,
  input logic              dtack_n,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_id,
  input logic [LVL_W-1:0]  res_level,
  input logic              res_timeout
);
  logic [LEVELS:0]  own_ext;
  logic [TMO_W:0]   low_cnt;
  logic [TMO_W:0]   eff_limit;

  assign own_ext   = {own_mask, 1'b0};
  assign eff_limit = (tmo_limit == '0) ? (TMO_W+1)'(1) : {1'b0, tmo_limit};

  always_ff @(posedge clk) begin
    if (!rst_n || ack_n) low_cnt <= '0;
    else                 low_cnt <= low_cnt + 1'b1;
  end

  p_owned_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> own_ext[lvl_addr]);

  p_lvl_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && $past(!ack_n)) |-> $stable(lvl_addr));

  p_release_on_dtack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ack_n && !dtack_n) |=> (ack_n && res_valid && !res_timeout));

  p_hold_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_n && !dtack_n) |=> ack_n);

  p_tmo_window_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_n |-> (low_cnt < eff_limit));

  p_hold_result_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_id) && $stable(res_level) && $stable(res_timeout)));

  p_no_ack_when_full_r8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> ack_n);
endmodule

bind irq_ack_handler irq_ack_checker #(
  .LEVELS(LEVELS), .DATA_W(DATA_W), .TMO_W(TMO_W)
) i_chk (
  .clk(clk), .rst_n(rst_n), .own_mask(own_mask), .tmo_limit(tmo_limit),
  .ack_n(ack_n), .lvl_addr(lvl_addr), .dtack_n(dtack_n),
  .res_valid(res_valid), .res_ready(res_ready), .res_id(res_id),
  .res_level(res_level), .res_timeout(res_timeout)
);

// File: tb/test_irq_ack_handler.sv
module test_irq_ack_handler;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  own_mask = '0;
  logic [15:0] tmo_limit = 16'd16;
  logic [6:0]  req_n = '1;
  logic        ack_n;
  logic [2:0]  lvl_addr;
  logic        dtack_n = 1'b1;
  logic [31:0] bus_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b0;
  logic [31:0] res_id;
  logic [2:0]  res_level;
  logic        res_timeout;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  irq_ack_handler i_irq_ack_handler (
    .clk(clk), .rst_n(rst_n), .own_mask(own_mask), .tmo_limit(tmo_limit),
    .req_n(req_n), .ack_n(ack_n), .lvl_addr(lvl_addr), .dtack_n(dtack_n),
    .bus_data(bus_data), .res_valid(res_valid), .res_ready(res_ready),
    .res_id(res_id), .res_level(res_level), .res_timeout(res_timeout)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ack(output int waited);
    waited = 0;
    do @(negedge clk); while (ack_n && waited++ < 6);
  endtask

  task automatic consume();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    check(!res_valid, "R8 result drained", res_valid, 0);
  endtask

  task automatic run_trial(input logic [6:0] mask, input logic [6:0] pat);
    int exp_lvl;
    int w;
    logic [31:0] val;
    bit quiet;
    exp_lvl = 0;
    for (int i = 0; i < 7; i++) if (pat[i] && mask[i]) exp_lvl = i + 1;
    val = {8'hC3, 1'b0, pat, 1'b0, mask, 8'(exp_lvl)};
    @(negedge clk);
    own_mask = mask;
    req_n = ~pat;
    if (exp_lvl == 0) begin
      quiet = 1;
      for (int k = 0; k < 4; k++) begin
        @(negedge clk);
        if (!ack_n) quiet = 0;
      end
      check(quiet, "R3 unowned ignored", {pat, mask}, 0);
      req_n = '1;
    end else begin
      wait_ack(w);
      check(!ack_n && w == 0, "R4 ack on first edge", w, 0);
      check(lvl_addr == 3'(exp_lvl), "R2 level select", lvl_addr, exp_lvl);
      dtack_n = 1'b0;
      bus_data = val;
      @(negedge clk);
      check(ack_n && res_valid && !res_timeout, "R5 release and post",
            {ack_n, res_valid, res_timeout}, 3'b110);
      check(res_id == val && res_level == 3'(exp_lvl), "R5 payload",
            {res_level, res_id}, {3'(exp_lvl), val});
      bus_data = '0;
      @(negedge clk);
      check(res_valid && res_id == val && ack_n, "R8 held under stall",
            {ack_n, res_valid, res_id}, {2'b11, val});
      req_n = '1;
      dtack_n = 1'b1;
      consume();
    end
  endtask

  task automatic run_timeout(input logic [15:0] lim, input int expect_len);
    int w;
    int len;
    tmo_limit = lim;
    own_mask = 7'h7F;
    bus_data = 32'hDEAD_BEEF;
    @(negedge clk);
    req_n = ~7'b0010000;
    wait_ack(w);
    len = 0;
    while (!ack_n && len < 100) begin
      len++;
      @(negedge clk);
    end
    check(len == expect_len, "R7 timeout length", len, expect_len);
    check(res_valid && res_timeout && res_id == 0 && res_level == 3'd5,
          "R7 timeout result", {res_valid, res_timeout, res_level, res_id},
          {2'b11, 3'd5, 32'd0});
    req_n = '1;
    consume();
    tmo_limit = 16'd16;
  endtask

  initial begin
    logic [6:0] masks [8];
    int w;
    masks = '{7'h7F, 7'h00, 7'h55, 7'h2A, 7'h0F, 7'h70, 7'h01, 7'h40};
    repeat (3) @(negedge clk);
    check(ack_n && lvl_addr == 0 && !res_valid, "R1 during reset",
          {ack_n, lvl_addr, res_valid}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    check(ack_n && lvl_addr == 0 && !res_valid, "R1 after reset",
          {ack_n, lvl_addr, res_valid}, 5'b10000);

    foreach (masks[m])
      for (int p = 0; p < 128; p++) run_trial(masks[m], 7'(p));

    run_timeout(16'd6, 6);
    run_timeout(16'd1, 1);
    run_timeout(16'd0, 1);

    // shared level 3, two interrupters in turn
    own_mask = 7'h7F;
    @(negedge clk);
    req_n = ~7'b0000100;
    wait_ack(w);
    check(lvl_addr == 3'd3, "R9 first on level 3", lvl_addr, 3);
    dtack_n = 1'b0;
    bus_data = 32'h0000_0011;
    @(negedge clk);
    repeat (3) @(negedge clk);
    check(ack_n, "R8 no ack while full", ack_n, 1);
    consume();
    repeat (3) @(negedge clk);
    check(ack_n, "R6 hold off until strobe high", ack_n, 1);
    dtack_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(!ack_n && lvl_addr == 3'd3, "R9 rerun same level", {ack_n, lvl_addr}, 4'b0011);
    dtack_n = 1'b0;
    bus_data = 32'h0000_0022;
    @(negedge clk);
    check(res_valid && res_id == 32'h22 && res_level == 3'd3, "R9 second id",
          res_id, 32'h22);
    req_n = '1;
    dtack_n = 1'b1;
    consume();
    repeat (4) @(negedge clk);
    check(ack_n, "R9 idle after line released", ack_n, 1);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule